// File: doc/BRIEF.md
# Gated Reverse-Playback Sequencer

This block runs a level-triggered reverse effect on a stereo stream that lives in an external circular sample memory. On each frame strobe it takes one signed 16-bit left and right sample. It decides whether that frame is stored. It drives the memory write and read ports and chooses whether the outputs carry the live input or samples read back from memory. A loud left sample, measured by magnitude against a fixed threshold, marks a buffer bottom a fixed distance behind the write pointer. Recording then carries on until the requested window length has been captured. After that, recording freezes and the window plays backwards, one stereo frame per strobe, down to the bottom.

When playback reaches the bottom, the block pulses a crossfade-start flag and resumes recording. Reverse reads continue for a fixed number of frames, so that a separate mixer can blend the two streams. A holdoff period follows, during which no new trigger is taken. The mixing arithmetic and the filter that produces the window length sit outside this block. The window length enters as the `buf_size` input.

The memory is assumed to be dual-ported, with a one-cycle registered read. Frame strobes must be at least four cycles apart.

Top module: `gated_reverse_ctrl`

## Requirements
- R1: A synchronous active-high reset sets mode to 0 (forward) and clears `out_left`, `out_right`, `mem_we`, `buf_bottom` and `xfade_start`. Both pointers are cleared, so the first stored frame writes its left sample at address 0.
- R2: A storing frame writes left at address W and right at address W+1, in the two cycles after the strobe edge. W then advances by 2 modulo 2^18. Modes 0, 1, 3 and 4 store every frame. Mode 1 stores every frame except the one that starts reversing.
- R3: In mode 0 a frame triggers when the left magnitude is at least 0x3900. The magnitude is the sample itself when bit 15 is 0 and its bitwise inverse when bit 15 is 1, compared unsigned. A trigger sets mode 1 (armed). 0x38FF and 0xC700 do not trigger; 0x3900 and 0xC6FF do.
- R4: On trigger, `buf_bottom` becomes W−0x800 modulo 2^18, where W is the trigger frame's left write address.
- R5: In mode 1, the frame in which W equals `buf_bottom`+`buf_size` (mod 2^18) stores nothing and sets mode 2 (reversing). Reading starts in that frame at address W−2.
- R6: Each reading frame reads left at address R−2 and then right at R−1, in the two cycles after the strobe edge. R then becomes R−2 (mod 2^18). A mode-2 frame never writes.
- R7: The reading frame whose left address equals `buf_bottom` sets mode 3 (crossfade) and raises `xfade_start` for exactly one cycle.
- R8: Mode 3 lasts 512 frames. Each of them both stores and keeps reading downward. The 512th sets mode 4 (holdoff).
- R9: A holdoff counter is loaded with 0x0F00 and drops by 2 per frame. Mode 4 therefore lasts 1920 frames, then returns to mode 0. No trigger is taken in mode 4, including its final frame.
- R10: No trigger check is made in modes 1, 2 and 3. `buf_bottom` changes only on the trigger frame.
- R11: Three clock edges after a strobe edge, the outputs show that frame's read-back left and right samples if the frame read memory. Otherwise they show that frame's input samples.
- R12: Mode, pointers and outputs change only in response to a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle frame strobe, at least 4 cycles apart |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| buf_size | input | 18 | Capture window length in addresses (even, above 0x800) |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_raddr` |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | 18 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| mem_raddr | output | 18 | Memory read address |
| out_left | output | 16 | Left output sample |
| out_right | output | 16 | Right output sample |
| mode | output | 3 | 0 forward, 1 armed, 2 reversing, 3 crossfade, 4 holdoff |
| buf_bottom | output | 18 | Current buffer bottom address |
| xfade_start | output | 1 | One-cycle pulse when crossfade begins |

## Verification
The bench drives the trigger magnitude at both sides of the threshold with both signs. A design that inverted negative samples wrongly, or used a strict comparison, would arm on 0xC700 or fail to arm on 0x3900.

The bench counts frames in the armed, reversing, crossfade and holdoff phases exactly. An off-by-one in the window compare or the counters shows up as a mode change one frame early or late, or as one write too many while reversing. A run that triggers at address 0 forces the bottom and the read pointer to wrap through 2^18, where a missing modulo would read the wrong addresses.

A loud sample on the last holdoff frame, and loud input throughout the armed and reversing phases, would move `buf_bottom` or re-arm a design that checked the trigger in those modes.

// File: rtl/gr_pkg.sv
package gr_pkg;
  typedef enum logic [2:0] {
    GR_FWD   = 3'd0,
    GR_ARMED = 3'd1,
    GR_REV   = 3'd2,
    GR_XFADE = 3'd3,
    GR_HOLD  = 3'd4
  } gr_mode_e;
endpackage

// File: rtl/gr_trigger.sv
module gr_trigger #(
  parameter int SW = 16,
  parameter logic [SW-1:0] THRESH = 16'h3900
) (
  input  logic [SW-1:0] sample,
  output logic          hit
);
  logic [SW-1:0] mag;

  // Ones-complement magnitude: cheap inversion instead of a negation carry chain
  always_comb begin
    mag = sample[SW-1] ? ~sample : sample;
    hit = (mag >= THRESH);
  end
endmodule

// File: rtl/gr_sequencer.sv
module gr_sequencer
  import gr_pkg::*;
#(
  parameter int          AW           = 18,
  parameter int unsigned BACKTRACK    = 32'h800,
  parameter int unsigned HOLDOFF      = 32'hF00,
  parameter int unsigned XFADE_FRAMES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          trig_hit,
  input  logic [AW-1:0] buf_size,
  output gr_mode_e      mode_o,
  output logic [AW-1:0] bottom_o,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr,
  output logic          xfade_start_o
);
  localparam int XCW = $clog2(XFADE_FRAMES + 1);
  localparam int HCW = $clog2(HOLDOFF + 1);
  localparam logic [AW-1:0] STEP = AW'(2);
  localparam logic [AW-1:0] BT   = AW'(BACKTRACK);

  gr_mode_e       mode_q, mode_d;
  logic [AW-1:0]  w_q, r_q, bottom_q, bottom_d, rd_base;
  logic [XCW-1:0] xcnt_q;
  logic [HCW-1:0] hcnt_q;
  logic           wr_now, rd_now, at_top, hload, xs, xs_q;

  always_comb begin
    rd_base  = (mode_q == GR_ARMED) ? w_q : r_q;
    rd_addr  = rd_base - STEP;
    at_top   = (w_q == bottom_q + buf_size);
    mode_d   = mode_q;
    bottom_d = bottom_q;
    wr_now   = 1'b0;
    rd_now   = 1'b0;
    hload    = 1'b0;
    xs       = 1'b0;
    case (mode_q)
      GR_FWD: begin
        wr_now = 1'b1;
        if (trig_hit) begin
          mode_d   = GR_ARMED;
          bottom_d = w_q - BT;
        end
      end
      GR_ARMED: begin
        if (at_top) begin
          rd_now = 1'b1;
          mode_d = GR_REV;
          if (rd_addr == bottom_q) begin
            mode_d = GR_XFADE;
            xs     = 1'b1;
          end
        end else begin
          wr_now = 1'b1;
        end
      end
      GR_REV: begin
        rd_now = 1'b1;
        if (rd_addr == bottom_q) begin
          mode_d = GR_XFADE;
          xs     = 1'b1;
        end
      end
      GR_XFADE: begin
        rd_now = 1'b1;
        wr_now = 1'b1;
        if (xcnt_q == XCW'(1)) begin
          mode_d = GR_HOLD;
          hload  = 1'b1;
        end
      end
      GR_HOLD: begin
        wr_now = 1'b1;
        if (hcnt_q == HCW'(2)) mode_d = GR_FWD;
      end
      default: mode_d = GR_FWD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= GR_FWD;
      w_q      <= '0;
      r_q      <= '0;
      bottom_q <= '0;
      xcnt_q   <= '0;
      hcnt_q   <= '0;
      xs_q     <= 1'b0;
    end else begin
      xs_q <= 1'b0;
      if (stb) begin
        mode_q   <= mode_d;
        bottom_q <= bottom_d;
        xs_q     <= xs;
        if (wr_now) w_q <= w_q + STEP;
        if (rd_now) r_q <= rd_addr;
        if (xs) xcnt_q <= XCW'(XFADE_FRAMES);
        else if (mode_q == GR_XFADE) xcnt_q <= xcnt_q - XCW'(1);
        if (hload) hcnt_q <= HCW'(HOLDOFF);
        else if (mode_q == GR_HOLD) hcnt_q <= hcnt_q - HCW'(2);
      end
    end
  end

  assign mode_o        = mode_q;
  assign bottom_o      = bottom_q;
  assign wr_go         = stb & wr_now;
  assign wr_addr       = w_q;
  assign rd_go         = stb & rd_now;
  assign xfade_start_o = xs_q;

  // R12
  mode_on_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(stb));

  // R10
  bottom_on_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    (bottom_q != $past(bottom_q)) |-> (mode_q == GR_ARMED && $past(mode_q) == GR_FWD));

  // R7
  xfade_pulse_mode_chk: assert property (@(posedge clk) disable iff (rst)
    xs_q |-> (mode_q == GR_XFADE));

  // R7
  xfade_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    xs_q |=> !xs_q);

  // R9
  hold_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == GR_HOLD && mode_q != GR_HOLD) |-> (mode_q == GR_FWD));
endmodule

// File: rtl/gr_memport.sv
module gr_memport #(
  parameter int AW = 18,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic [SW-1:0] in_l,
  input  logic [SW-1:0] in_r,
  input  logic [SW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [SW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic [SW-1:0] out_l,
  output logic [SW-1:0] out_r
);
  localparam int NPH = 3;

  logic [NPH-1:0] ph;
  logic [SW-1:0]  lat_l, lat_r, left_cap;
  logic           play_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      lat_l     <= '0;
      lat_r     <= '0;
      left_cap  <= '0;
      play_q    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      mem_raddr <= '0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      ph <= {ph[NPH-2:0], stb};
      if (stb) begin
        mem_we    <= wr_go;
        mem_waddr <= wr_addr;
        mem_wdata <= in_l;
        lat_l     <= in_l;
        lat_r     <= in_r;
        play_q    <= rd_go;
        if (rd_go) mem_raddr <= rd_addr;
      end else if (ph[0]) begin
        mem_waddr <= mem_waddr + AW'(1);
        mem_wdata <= lat_r;
        if (play_q) mem_raddr <= mem_raddr + AW'(1);
      end else begin
        mem_we <= 1'b0;
      end
      if (ph[1]) left_cap <= mem_rdata;
      if (ph[2]) begin
        out_l <= play_q ? left_cap : lat_l;
        out_r <= play_q ? mem_rdata : lat_r;
      end
    end
  end

  // R2
  right_follows_left_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) + AW'(1)));

  // R12
  stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    stb |-> (ph == '0));
endmodule

// File: rtl/gated_reverse_ctrl.sv
module gated_reverse_ctrl
  import gr_pkg::*;
#(
  parameter int              AW           = 18,
  parameter int              SW           = 16,
  parameter logic [SW-1:0]   THRESH       = 16'h3900,
  parameter int unsigned     BACKTRACK    = 32'h800,
  parameter int unsigned     HOLDOFF      = 32'hF00,
  parameter int unsigned     XFADE_FRAMES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_stb,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  input  logic [AW-1:0] buf_size,
  input  logic [SW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [SW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right,
  output logic [2:0]    mode,
  output logic [AW-1:0] buf_bottom,
  output logic          xfade_start
);
  gr_mode_e      mode_s;
  logic          hit, wr_go, rd_go;
  logic [AW-1:0] wr_addr, rd_addr;

  gr_trigger #(.SW(SW), .THRESH(THRESH)) u_trig (
    .sample (in_left),
    .hit    (hit)
  );

  gr_sequencer #(
    .AW(AW), .BACKTRACK(BACKTRACK), .HOLDOFF(HOLDOFF), .XFADE_FRAMES(XFADE_FRAMES)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .stb           (frame_stb),
    .trig_hit      (hit),
    .buf_size      (buf_size),
    .mode_o        (mode_s),
    .bottom_o      (buf_bottom),
    .wr_go         (wr_go),
    .wr_addr       (wr_addr),
    .rd_go         (rd_go),
    .rd_addr       (rd_addr),
    .xfade_start_o (xfade_start)
  );

  gr_memport #(.AW(AW), .SW(SW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .stb       (frame_stb),
    .wr_go     (wr_go),
    .wr_addr   (wr_addr),
    .rd_go     (rd_go),
    .rd_addr   (rd_addr),
    .in_l      (in_left),
    .in_r      (in_right),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .out_l     (out_left),
    .out_r     (out_right)
  );

  assign mode = mode_s;

  // R6
  no_write_reversing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($past(mode_s) != GR_REV));
endmodule

// File: tb/gated_reverse_ctrl_bench.sv
module gated_reverse_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_stb = 1'b0;
  logic [15:0] in_left = '0, in_right = '0;
  logic [17:0] buf_size = 18'h900;
  logic [15:0] mem_rdata;
  logic        mem_we, xfade_start;
  logic [17:0] mem_waddr, mem_raddr, buf_bottom;
  logic [15:0] mem_wdata, out_left, out_right;
  logic [2:0]  mode;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  gated_reverse_ctrl u_gated_reverse_ctrl (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .in_left(in_left), .in_right(in_right),
    .buf_size(buf_size), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .out_left(out_left), .out_right(out_right),
    .mode(mode), .buf_bottom(buf_bottom), .xfade_start(xfade_start)
  );

  function automatic logic [15:0] hashf(input logic [17:0] a);
    logic [17:0] t;
    t = a * 18'd7 + 18'h01357;
    return t[15:0] ^ {14'd0, t[17:16]};
  endfunction

  // synchronous read memory model with computed contents
  always_ff @(posedge clk) mem_rdata <= hashf(mem_raddr);

  logic        ob_we0, ob_we1, ob_xs, ob_xs1;
  logic [17:0] ob_wa0, ob_wa1, ob_ra0, ob_ra1, ob_bot;
  logic [15:0] ob_wd0, ob_wd1, ob_ol, ob_or;
  logic [2:0]  ob_mode;
  logic [17:0] exp_w, exp_bot, rd_a;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_frame(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    frame_stb = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    frame_stb = 1'b0; in_left = ~l; in_right = ~r;
    ob_mode = mode; ob_we0 = mem_we; ob_wa0 = mem_waddr; ob_wd0 = mem_wdata;
    ob_ra0 = mem_raddr; ob_xs = xfade_start; ob_bot = buf_bottom;
    @(negedge clk);
    ob_we1 = mem_we; ob_wa1 = mem_waddr; ob_wd1 = mem_wdata; ob_ra1 = mem_raddr; ob_xs1 = xfade_start;
    @(negedge clk);
    @(negedge clk);
    ob_ol = out_left; ob_or = out_right;
    @(negedge clk);
  endtask

  task automatic exp_write(input string tag, input logic [15:0] l, input logic [15:0] r);
    chk(ob_we0 && ob_we1, {tag, " write enable"}, {ob_we0, ob_we1}, 2'b11);
    chk(ob_wa0 == exp_w, {tag, " left addr"}, ob_wa0, exp_w);
    chk(ob_wd0 == l, {tag, " left data"}, ob_wd0, l);
    chk(ob_wa1 == exp_w + 18'd1, {tag, " right addr"}, ob_wa1, exp_w + 18'd1);
    chk(ob_wd1 == r, {tag, " right data"}, ob_wd1, r);
    exp_w = exp_w + 18'd2;
  endtask

  task automatic exp_read(input string tag, input logic [17:0] a);
    chk(ob_ra0 == a, {tag, " left read addr"}, ob_ra0, a);
    chk(ob_ra1 == a + 18'd1, {tag, " right read addr"}, ob_ra1, a + 18'd1);
    chk(ob_ol == hashf(a), {"R11 ", tag, " left out"}, ob_ol, hashf(a));
    chk(ob_or == hashf(a + 18'd1), {"R11 ", tag, " right out"}, ob_or, hashf(a + 18'd1));
  endtask

  task automatic exp_pass(input string tag, input logic [15:0] l, input logic [15:0] r);
    chk(ob_ol == l && ob_or == r, {"R11 ", tag, " pass-through"}, {ob_ol, ob_or}, {l, r});
  endtask

  task automatic run_cycle(input logic [15:0] trig_l, input logic [17:0] size);
    logic [17:0] target;
    int na, nr;
    buf_size = size;
    do_frame(trig_l, 16'h1111);
    exp_bot = exp_w - 18'h800;
    exp_write("R2 trigger frame", trig_l, 16'h1111);
    chk(ob_mode == 3'd1, "R3 trigger arms", ob_mode, 1);
    chk(ob_bot == exp_bot, "R4 bottom", ob_bot, exp_bot);
    exp_pass("R3", trig_l, 16'h1111);
    target = exp_bot + size;
    na = int'((size - 18'h800) / 2);
    nr = int'(size / 2) - 1;
    for (int i = 1; i <= na; i++) begin
      do_frame(16'h7FFF, 16'(i));
      chk(ob_bot == exp_bot, "R10 bottom held armed", ob_bot, exp_bot);
      if (i < na) begin
        exp_write("R5 armed", 16'h7FFF, 16'(i));
        chk(ob_mode == 3'd1, "R5 stays armed", ob_mode, 1);
        exp_pass("R5", 16'h7FFF, 16'(i));
      end else begin
        chk(!ob_we0 && !ob_we1, "R5 no write at top", {ob_we0, ob_we1}, 0);
        chk(ob_mode == 3'd2, "R5 reverse starts", ob_mode, 2);
        chk(exp_w == target, "R5 top address", exp_w, target);
        rd_a = target - 18'd2;
        exp_read("R5", rd_a);
      end
    end
    for (int j = 1; j <= nr; j++) begin
      rd_a = rd_a - 18'd2;
      do_frame(16'h8000, 16'(j));
      chk(!ob_we0 && !ob_we1, "R6 no write reversing", {ob_we0, ob_we1}, 0);
      exp_read("R6", rd_a);
      chk(ob_bot == exp_bot, "R10 bottom held reversing", ob_bot, exp_bot);
      if (j < nr) begin
        chk(ob_mode == 3'd2 && !ob_xs, "R7 still reversing", {ob_mode, ob_xs}, 4'b0100);
      end else begin
        chk(ob_mode == 3'd3, "R7 crossfade mode", ob_mode, 3);
        chk(ob_xs == 1'b1, "R7 crossfade pulse", ob_xs, 1);
        chk(ob_xs1 == 1'b0, "R7 pulse one cycle", ob_xs1, 0);
        chk(rd_a == exp_bot, "R7 last read at bottom", rd_a, exp_bot);
      end
    end
    for (int k = 1; k <= 512; k++) begin
      rd_a = rd_a - 18'd2;
      do_frame(16'h7000, 16'(k));
      exp_write("R8 crossfade", 16'h7000, 16'(k));
      exp_read("R8", rd_a);
      chk(ob_bot == exp_bot, "R10 bottom held crossfade", ob_bot, exp_bot);
      chk(ob_mode == ((k < 512) ? 3'd3 : 3'd4), "R8 crossfade length", ob_mode, (k < 512) ? 3 : 4);
    end
    for (int h = 1; h <= 1920; h++) begin
      logic [15:0] lv;
      lv = (h % 2 == 1) ? 16'h7FFF : 16'hC000;
      do_frame(lv, 16'(h));
      exp_write("R9 holdoff", lv, 16'(h));
      exp_pass("R9", lv, 16'(h));
      chk(ob_mode == ((h < 1920) ? 3'd4 : 3'd0), "R9 holdoff length", ob_mode, (h < 1920) ? 4 : 0);
    end
    do_frame(16'h0100, 16'h0200);
    chk(ob_mode == 3'd0, "R9 forward after holdoff", ob_mode, 0);
    exp_write("R2 after holdoff", 16'h0100, 16'h0200);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mode == 3'd0, "R1 reset mode", mode, 0);
    chk(out_left == 0 && out_right == 0, "R1 reset outputs", {out_left, out_right}, 0);
    chk(!mem_we && !xfade_start, "R1 reset strobes", {mem_we, xfade_start}, 0);
    chk(buf_bottom == 0, "R1 reset bottom", buf_bottom, 0);
    exp_w = 18'd0;
    // forward fill with sub-threshold values including both boundary magnitudes
    for (int n = 0; n < 1600; n++) begin
      logic [15:0] lv;
      lv = (n % 3 == 0) ? 16'h38FF : (n % 3 == 1) ? 16'hC700 : 16'(n * 5);
      do_frame(lv, 16'(n + 3));
      if (n == 0) chk(ob_wa0 == 18'd0, "R1 first write at zero", ob_wa0, 0);
      exp_write("R2 forward", lv, 16'(n + 3));
      chk(ob_mode == 3'd0, "R3 below threshold", ob_mode, 0);
      exp_pass("forward", lv, 16'(n + 3));
    end
    run_cycle(16'h3900, 18'h900);
    // R12: no strobe, no change
    repeat (20) @(negedge clk);
    chk(mode == 3'd0 && !mem_we, "R12 idle without strobe", {mode, mem_we}, 0);
    chk(out_left == 16'h0100 && out_right == 16'h0200, "R12 outputs held", {out_left, out_right}, 32'h01000200);
    // reset while armed
    do_frame(16'h7FFF, 16'h0001);
    chk(ob_mode == 3'd1, "R3 positive loud arms", ob_mode, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mode == 3'd0 && buf_bottom == 0, "R1 reset from armed", {mode, buf_bottom}, 0);
    chk(out_left == 0 && out_right == 0 && !mem_we, "R1 reset clears outputs", {out_left, out_right}, 0);
    exp_w = 18'd0;
    // immediate negative trigger at address 0: bottom and reads wrap
    run_cycle(16'hC6FF, 18'hA00);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule